// File: doc/BRIEF.md
# Burst Dimming PWM Generator

This block produces the low-frequency burst-dimming waveform that gates lamp drive on and off. An 8-bit brightness code sets the duty cycle. Code 0 stands for 0 V and code 255 for 3.3 V. Two configuration bits choose between a narrow window, codes 39 to 155 (about 0.5 V to 2.0 V), and the full 0 to 255 window, and select rising or falling slope. Inside the window the duty rises linearly from a programmable floor to 100%. Outside the window it is clamped to the end values.

Each rising edge of the dimming clock starts one burst period of 256 steps. The dimming clock is either an asynchronous external pin, passed through a two-flop synchronizer, or an internal divider. A two-bit band setting selects the step length so that 256 steps fit inside one dimming-clock period, whichever clock is used.

Several controllers can share one burst line. In source mode the block drives its own waveform onto the shared sync pin and enables the pin driver. In follower mode it releases the pin and uses the synchronized pin input as its burst signal.

Top module: `burst_dim_pwm`

## Requirements
- R1: With `wide_range_i`=0 and `neg_slope_i`=0, the duty is MIN_DUTY + (c-39)*(256-MIN_DUTY)/116 steps out of 256. Here c is `bright_i` clamped to 39..155, and the division rounds down.
- R2: With `neg_slope_i`=1, the position inside the window is mirrored, (hi-c) replacing (c-lo). The high end of the window then gives the minimum duty and the low end gives full duty.
- R3: With `wide_range_i`=1 the window is codes 0..255 and the divisor is 255. The same linear law applies for either slope.
- R4: Codes beyond the window ends are clamped: the duty never leaves MIN_DUTY..256. With positive slope, a code at or below the low end gives MIN_DUTY and a code at or above the high end gives 256.
- R5: A burst period lasts 256 steps. `dpwm_o` is high from the period start for exactly duty steps and low for the rest of the period.
- R6: A duty of 256 keeps `dpwm_o` high continuously, across period boundaries, with no low cycle.
- R7: The duty in use is loaded only at a period start. A change of `bright_i` or of the window settings during a period first takes effect in the next period.
- R8: With `ext_clk_sel_i`=1, a period starts only on a rising edge of `dim_clk_i`, after two-flop synchronization. With `ext_clk_sel_i`=0, the internal divider starts a period every OSC_STEPS steps.
- R9: With `follow_i`=0, `sync_oe_o` is 1 and `sync_o` equals `dpwm_o`.
- R10: With `follow_i`=1, `sync_oe_o` and `sync_o` are 0, and `dpwm_o` equals `sync_i` delayed by two clock cycles.
- R11: During reset and until the first period start, `dpwm_o` is low.
- R12: One step lasts BASE_DIV shifted left by `band_i` clock cycles, that is 1, 2, 4 or 8 cycles with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bright_i | input | 8 | Brightness code, 0 = 0 V, 255 = 3.3 V |
| wide_range_i | input | 1 | 0: window 39..155, 1: window 0..255 |
| neg_slope_i | input | 1 | 1: mirrored (falling) brightness law |
| ext_clk_sel_i | input | 1 | 1: external dimming clock, 0: internal divider |
| follow_i | input | 1 | 0: source mode, 1: follower mode |
| band_i | input | 2 | Step length select, BASE_DIV << band_i cycles |
| dim_clk_i | input | 1 | Asynchronous external dimming clock |
| sync_i | input | 1 | Input side of the shared sync pin |
| sync_o | output | 1 | Output side of the shared sync pin |
| sync_oe_o | output | 1 | Driver enable for the shared sync pin |
| dpwm_o | output | 1 | Burst-dimming gate signal |

## Verification
Assertions check the following on every cycle:
- the computed duty stays between the floor and full scale, and clamps at both ends of a positive window;
- the loaded duty holds steady between period starts;
- a full duty never lets the output drop;
- the pin direction, the mirroring in source mode and the two-cycle follower delay hold;
- a held-high external clock starts no period.

Only the bench scenarios can show the duty law itself. They sweep codes across all four window and slope settings, check band-dependent step lengths, replace the brightness in the middle of a burst, and stop the external clock.

// File: rtl/bdpwm_pkg.sv
package bdpwm_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned STEP_W    = 8;
  localparam int unsigned FULL_DUTY = 1 << STEP_W;
  localparam int unsigned DUTY_W    = STEP_W + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/bdpwm_sync.sv
module bdpwm_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end
endmodule

// File: rtl/bdpwm_duty_map.sv
module bdpwm_duty_map
  import bdpwm_pkg::*;
#(
  parameter int unsigned MIN_DUTY = 8,
  parameter int unsigned NAR_LO   = 39,
  parameter int unsigned NAR_HI   = 155
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t code_i,
  input  logic  wide_i,
  input  logic  neg_i,
  output duty_t duty_o
);
  localparam int unsigned PROD_W = CODE_W + DUTY_W;
  localparam int unsigned GAIN   = FULL_DUTY - MIN_DUTY;

  duty_t win_duty [2];

  // window 0: narrow, window 1: full code range
  for (genvar w = 0; w < 2; w++) begin : g_win
    localparam int unsigned LO   = (w == 0) ? NAR_LO : 0;
    localparam int unsigned HI   = (w == 0) ? NAR_HI : (1 << CODE_W) - 1;
    localparam int unsigned SPAN = HI - LO;
    localparam code_t LO_C   = CODE_W'(LO);
    localparam code_t HI_C   = CODE_W'(HI);
    localparam code_t SPAN_C = CODE_W'(SPAN);

    code_t              clamped, pos;
    logic [PROD_W-1:0]  prod;

    always_comb begin
      if (code_i <= LO_C)      clamped = LO_C;
      else if (code_i >= HI_C) clamped = HI_C;
      else                     clamped = code_i;
      pos = clamped - LO_C;
      if (neg_i) pos = SPAN_C - pos;
      prod = PROD_W'(pos) * PROD_W'(GAIN);
    end

    assign win_duty[w] = DUTY_W'(prod / PROD_W'(SPAN)) + DUTY_W'(MIN_DUTY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_o <= DUTY_W'(MIN_DUTY);
    else         duty_o <= wide_i ? win_duty[1] : win_duty[0];
  end

  a_r4_duty_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_o >= DUTY_W'(MIN_DUTY)) && (duty_o <= DUTY_W'(FULL_DUTY)));

  a_r4_clamp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!neg_i && !wide_i && code_i <= CODE_W'(NAR_LO)) |=> duty_o == DUTY_W'(MIN_DUTY));

  a_r4_clamp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!neg_i && !wide_i && code_i >= CODE_W'(NAR_HI)) |=> duty_o == DUTY_W'(FULL_DUTY));
endmodule

// File: rtl/bdpwm_tick_gen.sv
module bdpwm_tick_gen #(
  parameter int unsigned BASE_DIV  = 1,
  parameter int unsigned OSC_STEPS = 264
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_sel_i,
  input  logic [1:0] band_i,
  input  logic       ext_clk_s_i,
  output logic       start_o,
  output logic       step_o
);
  localparam int unsigned MAX_DIV = BASE_DIV << 3;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned OSC_MAX = OSC_STEPS * MAX_DIV;
  localparam int unsigned OSC_W   = $clog2(OSC_MAX + 1);

  logic [DIV_W-1:0] div, step_cnt;
  logic [OSC_W-1:0] osc_len, osc_cnt;
  logic             osc_wrap, ext_d, ext_rise, step_due;

  assign div     = DIV_W'(BASE_DIV) << band_i;
  assign osc_len = OSC_W'(OSC_STEPS) * OSC_W'(div);

  // internal dimming clock: free-running divider
  assign osc_wrap = osc_cnt >= (osc_len - OSC_W'(1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       osc_cnt <= '0;
    else if (osc_wrap) osc_cnt <= '0;
    else               osc_cnt <= osc_cnt + OSC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d <= 1'b0;
    else         ext_d <= ext_clk_s_i;
  end
  assign ext_rise = ext_clk_s_i & ~ext_d;

  assign start_o = ext_sel_i ? ext_rise : osc_wrap;

  // step prescaler realigned at each period start
  assign step_due = step_cnt >= (div - DIV_W'(1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  step_cnt <= '0;
    else if (start_o || step_due) step_cnt <= '0;
    else                          step_cnt <= step_cnt + DIV_W'(1);
  end
  assign step_o = step_due & ~start_o;

  a_r12_step_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (!step_o || div == DIV_W'(1)));

  a_r8_ext_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && $past(ext_clk_s_i)) |-> !start_o);
endmodule

// File: rtl/bdpwm_burst_ctr.sv
module bdpwm_burst_ctr
  import bdpwm_pkg::*;
#(
  parameter int unsigned MIN_DUTY = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  step_i,
  input  duty_t duty_i,
  output logic  pwm_o
);
  localparam step_t LAST_STEP = STEP_W'(FULL_DUTY - 1);

  step_t cnt_q;
  duty_t duty_q;
  logic  active_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      duty_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      duty_q   <= duty_i;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (step_i && active_q && !done_q) begin
      if (cnt_q == LAST_STEP) done_q <= 1'b1;
      else                    cnt_q  <= cnt_q + STEP_W'(1);
    end
  end

  // after the last step only a full duty keeps the line high
  always_comb begin
    if (!active_q)   pwm_o = 1'b0;
    else if (done_q) pwm_o = (duty_q == DUTY_W'(FULL_DUTY));
    else             pwm_o = ({1'b0, cnt_q} < duty_q);
  end

  a_r7_duty_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(duty_q));

  a_r6_full_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && duty_q == DUTY_W'(FULL_DUTY)) |=> pwm_o);

  a_r4_loaded_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> duty_q >= DUTY_W'(MIN_DUTY));
endmodule

// File: rtl/burst_dim_pwm.sv
module burst_dim_pwm
  import bdpwm_pkg::*;
#(
  parameter int unsigned MIN_DUTY  = 8,
  parameter int unsigned NAR_LO    = 39,
  parameter int unsigned NAR_HI    = 155,
  parameter int unsigned BASE_DIV  = 1,
  parameter int unsigned OSC_STEPS = 264
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] bright_i,
  input  logic       wide_range_i,
  input  logic       neg_slope_i,
  input  logic       ext_clk_sel_i,
  input  logic       follow_i,
  input  logic [1:0] band_i,
  input  logic       dim_clk_i,
  input  logic       sync_i,
  output logic       sync_o,
  output logic       sync_oe_o,
  output logic       dpwm_o
);
  logic  dim_clk_s, sync_s, start, step, gen_pwm;
  duty_t duty;

  bdpwm_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dim_clk_i, sync_i}),
    .q_o   ({dim_clk_s, sync_s})
  );

  bdpwm_duty_map #(
    .MIN_DUTY(MIN_DUTY),
    .NAR_LO  (NAR_LO),
    .NAR_HI  (NAR_HI)
  ) u_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(bright_i),
    .wide_i(wide_range_i),
    .neg_i (neg_slope_i),
    .duty_o(duty)
  );

  bdpwm_tick_gen #(
    .BASE_DIV (BASE_DIV),
    .OSC_STEPS(OSC_STEPS)
  ) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_sel_i  (ext_clk_sel_i),
    .band_i     (band_i),
    .ext_clk_s_i(dim_clk_s),
    .start_o    (start),
    .step_o     (step)
  );

  bdpwm_burst_ctr #(.MIN_DUTY(MIN_DUTY)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .step_i (step),
    .duty_i (duty),
    .pwm_o  (gen_pwm)
  );

  assign sync_oe_o = ~follow_i;
  assign sync_o    = follow_i ? 1'b0 : gen_pwm;
  assign dpwm_o    = follow_i ? sync_s : gen_pwm;

  // cycles since reset, used to keep the delay check inside valid history
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  a_r9_src_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !follow_i |-> (sync_oe_o && sync_o == dpwm_o));

  a_r10_rx_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    follow_i |-> (!sync_oe_o && !sync_o));

  a_r10_rx_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (follow_i && age_q == 2'd2) |-> dpwm_o == $past(sync_i, 2));
endmodule

// File: tb/burst_dim_pwm_tb.sv
module burst_dim_pwm_tb;
  localparam int OSC_STEPS = 264;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bright = '0;
  logic       wide = 1'b0, neg = 1'b0, ext_sel = 1'b0, follow = 1'b0;
  logic [1:0] band = '0;
  logic       dim_clk = 1'b0, sync_in = 1'b0;
  logic       sync_out, sync_oe, dpwm;

  int  n_cmp = 0, n_bad = 0;
  bit  ext_en = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  burst_dim_pwm u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bright_i     (bright),
    .wide_range_i (wide),
    .neg_slope_i  (neg),
    .ext_clk_sel_i(ext_sel),
    .follow_i     (follow),
    .band_i       (band),
    .dim_clk_i    (dim_clk),
    .sync_i       (sync_in),
    .sync_o       (sync_out),
    .sync_oe_o    (sync_oe),
    .dpwm_o       (dpwm)
  );

  // external dimming clock, 600-cycle period
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!ext_en) begin
        dim_clk = 1'b0;
        cnt = 0;
      end else if (++cnt == 300) begin
        dim_clk = ~dim_clk;
        cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_duty(input int code, input bit w, input bit n);
    int lo = w ? 0 : 39;
    int hi = w ? 255 : 155;
    int c  = (code < lo) ? lo : ((code > hi) ? hi : code);
    int p  = c - lo;
    if (n) p = (hi - lo) - p;
    return 8 + p * 248 / (hi - lo);
  endfunction

  function automatic int exp_high(input int d, input int div, input int len);
    return (d == 256) ? len : d * div;
  endfunction

  task automatic count_high(input int win, output int hi);
    hi = 0;
    repeat (win) begin
      @(negedge clk);
      if (dpwm) hi++;
    end
  endtask

  task automatic run_len(output int len);
    len = 0;
    @(negedge clk);
    while (dpwm !== 1'b0) @(negedge clk);
    while (dpwm !== 1'b1) @(negedge clk);
    while (dpwm === 1'b1) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int codes[24] = '{0, 1, 20, 38, 39, 40, 41, 60, 77, 97, 100, 120,
                      128, 140, 153, 154, 155, 156, 157, 180, 200, 230, 254, 255};
    int hi, len, run;

    // R11 / R9: reset state
    repeat (5) @(negedge clk);
    chk("R11 reset dpwm", dpwm, 0);
    chk("R9 reset oe", sync_oe, 1);
    chk("R9 reset sync_o", sync_out, 0);
    rst_n = 1'b1;
    count_high(250, hi);
    chk("R11 low before first start", hi, 0);

    // R1 R2 R3 R4 R5 R6: sweep over window/slope settings, band 0
    len = OSC_STEPS;
    for (int m = 0; m < 4; m++) begin
      wide = m[1];
      neg  = m[0];
      foreach (codes[i]) begin
        bright = 8'(codes[i]);
        repeat (len + 3) @(negedge clk);
        count_high(len, hi);
        chk(m[1] ? "R3 wide map" : (m[0] ? "R2 neg map" : "R1 R4 R5 R6 narrow map"),
            hi, exp_high(exp_duty(codes[i], m[1], m[0]), 1, len));
      end
    end
    chk("R9 source oe", sync_oe, 1);
    chk("R9 source mirror", sync_out, dpwm);

    // R7: mid-burst brightness change waits for the next period
    wide = 1'b1; neg = 1'b0; bright = 8'd50;
    repeat (2 * len + 4) @(negedge clk);
    while (dpwm !== 1'b0) @(negedge clk);
    while (dpwm !== 1'b1) @(negedge clk);
    bright = 8'd220;
    run = 0;
    while (dpwm === 1'b1) begin
      run++;
      @(negedge clk);
    end
    chk("R7 current burst keeps old duty", run, exp_duty(50, 1, 0));
    run_len(run);
    chk("R7 next burst uses new duty", run, exp_duty(220, 1, 0));

    // R12: band scales the step length
    band = 2'd2; bright = 8'd100;
    len = OSC_STEPS * 4;
    repeat (len + 3) @(negedge clk);
    count_high(len, hi);
    chk("R12 band 2", hi, exp_high(exp_duty(100, 1, 0), 4, len));
    band = 2'd1; neg = 1'b1; bright = 8'd128;
    len = OSC_STEPS * 2;
    repeat (len + 3) @(negedge clk);
    count_high(len, hi);
    chk("R12 band 1", hi, exp_high(exp_duty(128, 1, 1), 2, len));
    band = 2'd3; neg = 1'b0; bright = 8'd255;
    len = OSC_STEPS * 8;
    repeat (len + 3) @(negedge clk);
    count_high(len, hi);
    chk("R12 R6 band 3 full", hi, len);

    // R8: external dimming clock
    band = 2'd1; bright = 8'd100; ext_en = 1'b1; ext_sel = 1'b1;
    repeat (1300) @(negedge clk);
    count_high(600, hi);
    chk("R8 external period", hi, exp_high(exp_duty(100, 1, 0), 2, 600));
    bright = 8'd255;
    repeat (1300) @(negedge clk);
    count_high(600, hi);
    chk("R8 R6 external full", hi, 600);
    bright = 8'd100;
    repeat (1300) @(negedge clk);
    ext_en = 1'b0;
    repeat (700) @(negedge clk);
    count_high(600, hi);
    chk("R8 stopped clock no burst", hi, 0);

    // R10: follower mode
    follow = 1'b1;
    @(negedge clk);
    chk("R10 oe released", sync_oe, 0);
    chk("R10 sync_o quiet", sync_out, 0);
    for (int i = 0; i < 16; i++) begin
      sync_in = ((i * 5) % 3) == 1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk("R10 follow sync_i", dpwm, sync_in);
      chk("R10 sync_o quiet", sync_out, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule